// File: doc/BRIEF.md
# LCD Controller Register and Interrupt Bank

This block is the software-visible front of a colour LCD controller. It sits on a simple 32-bit bus that is addressed in words and has separate read and write strobes. It holds the panel timing words, the two panel base addresses, the control word and the interrupt mask. It keeps a raw event status and derives a masked view from it. A write-one-to-clear register removes events. A bank of read-only identification bytes sits at the top of the address window.

The block decodes the active column and row counts directly from fields of the first two timing words. It also presents the fields of the control word on dedicated outputs. An internal frame timer is a two-state machine. `T_IDLE` waits until a control write leaves the controller enabled. That write moves it to `T_RUN` with the period counter at zero. A control write that disables the controller returns it to `T_IDLE`. A control write that keeps it enabled stays in `T_RUN` and restarts the count. In `T_RUN` the timer fires once every `FRAME_CYCLES` clocks. Each firing sets two status events. One registered, level-sensitive interrupt line reports whether any unmasked event is pending.

A strap input selects an alternate address map in which the control and mask registers trade places.

Top module: `lcdc_regbank`

## Requirements
- R1: After reset, every register reads 0, `irq_o` is low and the frame timer is idle.
- R2: The word offsets are mapped as follows: 0-3 are the timing words, 4 is the upper base, 5 is the lower base, 6 is the mask and 7 is the control word (with the strap low), 8 is the raw status and 9 is the masked status. These registers read back what was written. Read data and the error flag are registered and valid on the cycle after the read strobe. Read data holds its value while no read is made.
- R3: With `alt_map_i` high, offset 6 reaches the control word and offset 7 reaches the mask, for both reads and writes.
- R4: `cols_o` equals (timing0[7:2] + 1) * 16, and `rows_o` equals timing1[9:0] + 1. Both range up to 1024.
- R5: `depth_o` is control[3:1]. `bgr_o` is control bit 8, `be_byte_o` is control bit 9 and `be_pix_o` is control bit 10. `enabled_o` is high only when control bit 0 and control bit 11 are both 1.
- R6: When a control write leaves the controller enabled at edge E, the raw status bits 2 and 3 are set at edge E+FRAME_CYCLES and again every FRAME_CYCLES clocks after that. With only one of bit 0 and bit 11 set, no event is raised.
- R7: A control write that disables the controller stops the timer. A control write that leaves the controller enabled restarts the period from zero, and that write's own cycle never fires an event.
- R8: The masked status (offset 9) reads as raw AND mask. `irq_o` is high on the cycle after raw AND mask is nonzero, and low on the cycle after it is zero.
- R9: Writing offset 10 clears each raw bit written as 1. If a timer event falls in the same cycle, the set takes priority. Writes to offsets 8, 9, 11 and 12 change nothing.
- R10: Offsets 11 and 12 read back the upper and lower base values.
- R11: The eight words at the top of the window (word offsets 0x3F8 to 0x3FF) return one identification byte each. With the strap low the bytes are 51 13 06 00 0D F0 05 B1. With the strap high they are 52 13 26 00 0D F0 05 B1 (hex).
- R12: A read of any other offset, offset 10 included, returns 0 and pulses `rd_err_o` for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| alt_map_i | input | 1 | Strap selecting the alternate control/mask address map |
| addr_i | input | ADDR_W | Word address |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Registered read data |
| rd_err_o | output | 1 | Pulse: the last read hit an unmapped offset |
| irq_o | output | 1 | Level interrupt, registered |
| cols_o | output | 11 | Active columns |
| rows_o | output | 11 | Active rows |
| enabled_o | output | 1 | Enable and power bits are both set |
| depth_o | output | 3 | Pixel-depth field |
| bgr_o | output | 1 | Blue/red swap selected |
| be_byte_o | output | 1 | Big-endian byte order selected |
| be_pix_o | output | 1 | Big-endian pixel order within bytes selected |

## Verification
Read data and the error flag are due one edge after the read strobe. Register fields and the decoded outputs are due one edge after the write. A timer event is due FRAME_CYCLES edges after the control write that enabled the timer. The interrupt line follows one edge after the status or the mask changes. The bench keeps a behavioural model that it advances on each rising edge from the same strobes the design sees. It compares every output on the following falling edge, so each result is checked exactly in the cycle it is due. Directed reads pin down the boundary cases, including a restart just before a period ends and a clear that lands on the event cycle.

// File: rtl/lcdc_pkg.sv
package lcdc_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned DIM_W  = 11;

    // word offsets
    localparam int unsigned OFF_UPBASE = 4;
    localparam int unsigned OFF_LPBASE = 5;
    localparam int unsigned OFF_LOWSEL = 6;
    localparam int unsigned OFF_HIGSEL = 7;
    localparam int unsigned OFF_RAW    = 8;
    localparam int unsigned OFF_MASKED = 9;
    localparam int unsigned OFF_CLEAR  = 10;
    localparam int unsigned OFF_UPCUR  = 11;
    localparam int unsigned OFF_LPCUR  = 12;

    // control bit positions
    localparam int unsigned CB_EN     = 0;
    localparam int unsigned CB_BGR    = 8;
    localparam int unsigned CB_BEBYTE = 9;
    localparam int unsigned CB_BEPIX  = 10;
    localparam int unsigned CB_PWR    = 11;

    // raw status event positions
    localparam int unsigned EV_NEXTBASE = 2;
    localparam int unsigned EV_VCOMP    = 3;

    typedef struct packed {
        logic [2:0] depth;
        logic       bgr;
        logic       be_byte;
        logic       be_pix;
        logic       enabled;
    } lcd_mode_t;

    function automatic lcd_mode_t decode_mode(input logic [DATA_W-1:0] c);
        lcd_mode_t m;
        m.depth   = c[3:1];
        m.bgr     = c[CB_BGR];
        m.be_byte = c[CB_BEBYTE];
        m.be_pix  = c[CB_BEPIX];
        m.enabled = c[CB_EN] & c[CB_PWR];
        return m;
    endfunction

    function automatic logic [7:0] id_byte(input logic alt, input logic [2:0] idx);
        logic [7:0] b;
        unique case (idx)
            3'd0: b = alt ? 8'h52 : 8'h51;
            3'd1: b = 8'h13;
            3'd2: b = alt ? 8'h26 : 8'h06;
            3'd3: b = 8'h00;
            3'd4: b = 8'h0D;
            3'd5: b = 8'hF0;
            3'd6: b = 8'h05;
            default: b = 8'hB1;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/lcdc_frame_timer.sv
module lcdc_frame_timer #(
    parameter int unsigned FRAME_CYCLES = 1666667
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_wr_i,
    input  logic en_wr_i,
    input  logic en_now_i,
    output logic tick_o
);
    localparam int unsigned CNT_W = (FRAME_CYCLES > 1) ? $clog2(FRAME_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_CYCLES - 1);

    typedef enum logic {T_IDLE, T_RUN} tstate_t;

    tstate_t          state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            T_IDLE: begin
                if (ctl_wr_i && en_wr_i) begin
                    state_d = T_RUN;
                    cnt_d   = '0;
                end
            end
            T_RUN: begin
                if (ctl_wr_i) begin
                    state_d = en_wr_i ? T_RUN : T_IDLE;
                    cnt_d   = '0;
                end else if (cnt_q == LAST) begin
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                state_d = T_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= T_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        tick_o = (state_q == T_RUN) && (cnt_q == LAST) && !ctl_wr_i;
    end

    // R6: an event is only raised while the stored control word is enabled
    assert_tick_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> en_now_i);

    // R7: a disabling control write silences the timer from the next cycle
    assert_disable_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr_i && !en_wr_i) |=> !tick_o);

endmodule

// File: rtl/lcdc_irq_unit.sv
module lcdc_irq_unit
    import lcdc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mask_wr_i,
    input  logic              clr_wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              tick_i,
    output logic [DATA_W-1:0] mask_o,
    output logic [DATA_W-1:0] raw_o,
    output logic [DATA_W-1:0] masked_o,
    output logic              irq_o
);
    logic [DATA_W-1:0] mask_q;
    logic [1:0]        ev_q;
    logic [1:0]        ev_clr;
    logic              irq_q;

    always_comb begin
        ev_clr = clr_wr_i ? {wdata_i[EV_VCOMP], wdata_i[EV_NEXTBASE]} : 2'b00;
        raw_o  = '0;
        raw_o[EV_NEXTBASE] = ev_q[0];
        raw_o[EV_VCOMP]    = ev_q[1];
        mask_o   = mask_q;
        masked_o = raw_o & mask_q;
        irq_o    = irq_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            ev_q   <= 2'b00;
            irq_q  <= 1'b0;
        end else begin
            if (mask_wr_i) begin
                mask_q <= wdata_i;
            end
            ev_q  <= (ev_q & ~ev_clr) | {tick_i, tick_i};
            irq_q <= |masked_o;
        end
    end

    // R6: a timer event sets both status bits
    assert_tick_sets_events_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> (raw_o[EV_VCOMP] && raw_o[EV_NEXTBASE]));

    // R9: a clear of the compare event without a concurrent event removes it
    assert_clear_removes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr_i && !tick_i && wdata_i[EV_VCOMP]) |=> !raw_o[EV_VCOMP]);

endmodule

// File: rtl/lcdc_regbank.sv
module lcdc_regbank
    import lcdc_pkg::*;
#(
    parameter int unsigned ADDR_W       = 10,
    parameter int unsigned FRAME_CYCLES = 1666667
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alt_map_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [31:0]       wdata_i,
    input  logic              rd_en_i,
    output logic [31:0]       rdata_o,
    output logic              rd_err_o,
    output logic              irq_o,
    output logic [10:0]       cols_o,
    output logic [10:0]       rows_o,
    output logic              enabled_o,
    output logic [2:0]        depth_o,
    output logic              bgr_o,
    output logic              be_byte_o,
    output logic              be_pix_o
);
    localparam int unsigned   N_TIMING = 4;
    localparam logic [ADDR_W-1:0] ID_BASE = ADDR_W'((1 << ADDR_W) - 8);
    localparam logic [ADDR_W-1:0] A_CTRL_STD = ADDR_W'(OFF_HIGSEL);
    localparam logic [ADDR_W-1:0] A_CTRL_ALT = ADDR_W'(OFF_LOWSEL);

    logic [DATA_W-1:0] tim_q [N_TIMING];
    logic [DATA_W-1:0] up_q, lp_q, ctrl_q;
    logic [DATA_W-1:0] mask_w, raw_w, masked_w;
    logic [ADDR_W-1:0] a_ctrl, a_mask;
    logic              ctl_wr, mask_wr, clr_wr, tick;
    logic [DATA_W-1:0] rd_val;
    logic              rd_miss;
    lcd_mode_t         mode;

    // address map selection by strap
    always_comb begin
        a_ctrl  = alt_map_i ? A_CTRL_ALT : A_CTRL_STD;
        a_mask  = alt_map_i ? A_CTRL_STD : A_CTRL_ALT;
        ctl_wr  = wr_en_i && (addr_i == a_ctrl);
        mask_wr = wr_en_i && (addr_i == a_mask);
        clr_wr  = wr_en_i && (addr_i == ADDR_W'(OFF_CLEAR));
    end

    genvar g;
    generate
        for (g = 0; g < N_TIMING; g++) begin : g_timing
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    tim_q[g] <= '0;
                end else if (wr_en_i && (addr_i == ADDR_W'(g))) begin
                    tim_q[g] <= wdata_i;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            up_q   <= '0;
            lp_q   <= '0;
            ctrl_q <= '0;
        end else begin
            if (wr_en_i && (addr_i == ADDR_W'(OFF_UPBASE))) up_q <= wdata_i;
            if (wr_en_i && (addr_i == ADDR_W'(OFF_LPBASE))) lp_q <= wdata_i;
            if (ctl_wr) ctrl_q <= wdata_i;
        end
    end

    lcdc_frame_timer #(
        .FRAME_CYCLES(FRAME_CYCLES)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_wr_i (ctl_wr),
        .en_wr_i  (wdata_i[CB_EN] & wdata_i[CB_PWR]),
        .en_now_i (mode.enabled),
        .tick_o   (tick)
    );

    lcdc_irq_unit u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .mask_wr_i (mask_wr),
        .clr_wr_i  (clr_wr),
        .wdata_i   (wdata_i),
        .tick_i    (tick),
        .mask_o    (mask_w),
        .raw_o     (raw_w),
        .masked_o  (masked_w),
        .irq_o     (irq_o)
    );

    // read decode
    always_comb begin
        rd_val  = '0;
        rd_miss = 1'b0;
        if (addr_i >= ID_BASE) begin
            rd_val = {24'b0, id_byte(alt_map_i, addr_i[2:0])};
        end else if (addr_i < ADDR_W'(N_TIMING)) begin
            rd_val = tim_q[addr_i[1:0]];
        end else if (addr_i == a_ctrl) begin
            rd_val = ctrl_q;
        end else if (addr_i == a_mask) begin
            rd_val = mask_w;
        end else if (addr_i == ADDR_W'(OFF_UPBASE) || addr_i == ADDR_W'(OFF_UPCUR)) begin
            rd_val = up_q;
        end else if (addr_i == ADDR_W'(OFF_LPBASE) || addr_i == ADDR_W'(OFF_LPCUR)) begin
            rd_val = lp_q;
        end else if (addr_i == ADDR_W'(OFF_RAW)) begin
            rd_val = raw_w;
        end else if (addr_i == ADDR_W'(OFF_MASKED)) begin
            rd_val = masked_w;
        end else begin
            rd_miss = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_o  <= '0;
            rd_err_o <= 1'b0;
        end else begin
            rd_err_o <= rd_en_i && rd_miss;
            if (rd_en_i) rdata_o <= rd_val;
        end
    end

    // decoded outputs
    always_comb begin
        mode      = decode_mode(ctrl_q);
        enabled_o = mode.enabled;
        depth_o   = mode.depth;
        bgr_o     = mode.bgr;
        be_byte_o = mode.be_byte;
        be_pix_o  = mode.be_pix;
        cols_o    = ({5'b0, tim_q[0][7:2]} + 11'd1) << 4;
        rows_o    = {1'b0, tim_q[1][9:0]} + 11'd1;
    end

    // R12: an unmapped read returns zero and flags it
    assert_unmapped_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && rd_miss) |=> (rd_err_o && rdata_o == 32'h0));

    // R3: in the alternate map offset 6 writes the control word
    assert_alt_swap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && alt_map_i && addr_i == ADDR_W'(OFF_LOWSEL)) |=> (ctrl_q == $past(wdata_i)));

endmodule

// File: tb/lcdc_regbank_bench.sv
module lcdc_regbank_bench;
    localparam int unsigned AW = 10;
    localparam int unsigned NF = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          alt = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          wr = 1'b0;
    logic [31:0]   wdata = '0;
    logic          rd = 1'b0;
    logic [31:0]   rdata_o;
    logic          rd_err_o, irq_o, enabled_o, bgr_o, be_byte_o, be_pix_o;
    logic [10:0]   cols_o, rows_o;
    logic [2:0]    depth_o;

    int vec_cnt = 0;
    int fail_cnt = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    lcdc_regbank #(.ADDR_W(AW), .FRAME_CYCLES(NF)) u_lcdc_regbank (
        .clk(clk), .rst_n(rst_n), .alt_map_i(alt), .addr_i(addr),
        .wr_en_i(wr), .wdata_i(wdata), .rd_en_i(rd), .rdata_o(rdata_o),
        .rd_err_o(rd_err_o), .irq_o(irq_o), .cols_o(cols_o), .rows_o(rows_o),
        .enabled_o(enabled_o), .depth_o(depth_o), .bgr_o(bgr_o),
        .be_byte_o(be_byte_o), .be_pix_o(be_pix_o)
    );

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_tim [4];
    logic [31:0] m_up, m_lp, m_ctrl, m_mask, m_raw, m_rdata;
    logic        m_err, m_irq, m_run;
    int          m_cnt;
    byte unsigned id_std [8] = '{8'h51, 8'h13, 8'h06, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    byte unsigned id_alt [8] = '{8'h52, 8'h13, 8'h26, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

    function automatic logic [31:0] m_read(input int a, input logic s, output logic miss);
        miss = 1'b0;
        if (a >= 1016) return s ? 32'(id_alt[a - 1016]) : 32'(id_std[a - 1016]);
        case (a)
            0, 1, 2, 3: return m_tim[a];
            4, 11: return m_up;
            5, 12: return m_lp;
            6: return s ? m_ctrl : m_mask;
            7: return s ? m_mask : m_ctrl;
            8: return m_raw;
            9: return m_raw & m_mask;
            default: begin miss = 1'b1; return 32'h0; end
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) m_tim[i] = '0;
            m_up = '0; m_lp = '0; m_ctrl = '0; m_mask = '0; m_raw = '0;
            m_rdata = '0; m_err = 1'b0; m_irq = 1'b0; m_run = 1'b0; m_cnt = 0;
        end else begin
            int a;
            logic cw, tk, nirq, miss;
            logic [31:0] clr;
            a = int'(addr);
            cw = wr && (a == (alt ? 6 : 7));
            tk = m_run && (m_cnt == NF - 1) && !cw;
            nirq = (m_raw & m_mask) != 0;
            if (rd) begin
                m_rdata = m_read(a, alt, miss);
                m_err = miss;
            end else begin
                m_err = 1'b0;
            end
            clr = (wr && a == 10) ? wdata : 32'h0;
            if (wr) begin
                if (a < 4) m_tim[a] = wdata;
                if (a == 4) m_up = wdata;
                if (a == 5) m_lp = wdata;
                if (a == (alt ? 7 : 6)) m_mask = wdata;
                if (cw) m_ctrl = wdata;
            end
            if (cw) begin
                m_run = wdata[0] && wdata[11];
                m_cnt = 0;
            end else if (m_run) begin
                m_cnt = (m_cnt == NF - 1) ? 0 : m_cnt + 1;
            end
            m_raw = (m_raw & ~clr) | (tk ? 32'hC : 32'h0);
            m_irq = nirq;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vec_cnt++;
        if (act !== exp) begin
            fail_cnt++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R2 rdata", rdata_o, m_rdata);
            chk("R12 rd_err", 32'(rd_err_o), 32'(m_err));
            chk("R8 irq", 32'(irq_o), 32'(m_irq));
            chk("R4 cols", 32'(cols_o), ((m_tim[0] & 32'hFC) + 32'd4) * 32'd4);
            chk("R4 rows", 32'(rows_o), (m_tim[1] & 32'h3FF) + 32'd1);
            chk("R5 enabled", 32'(enabled_o), 32'(m_ctrl[0] & m_ctrl[11]));
            chk("R5 fields", {25'b0, be_pix_o, be_byte_o, bgr_o, depth_o, 1'b0},
                {25'b0, m_ctrl[10], m_ctrl[9], m_ctrl[8], m_ctrl[3:1], 1'b0});
        end
    end

    // ---------------- stimulus ----------------
    task automatic wr_reg(input int a, input logic [31:0] d);
        addr = AW'(a); wdata = d; wr = 1'b1;
        @(posedge clk); @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_check(input int a, input logic [31:0] exp, input logic eerr, input string tag);
        addr = AW'(a); rd = 1'b1;
        @(posedge clk); @(negedge clk);
        rd = 1'b0;
        chk(tag, rdata_o, exp);
        chk(tag, 32'(rd_err_o), 32'(eerr));
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, fail_cnt);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        vec_cnt++; fail_cnt++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        chk("R1 irq", 32'(irq_o), 32'h0);
        chk("R1 enabled", 32'(enabled_o), 32'h0);
        rd_check(7, 32'h0, 1'b0, "R1 control");
        rd_check(8, 32'h0, 1'b0, "R1 raw");

        // R4 geometry and R2 readback
        wr_reg(0, 32'h0000_00A8);
        wr_reg(1, 32'h0000_00EF);
        chk("R4 cols 688", 32'(cols_o), 32'd688);
        chk("R4 rows 240", 32'(rows_o), 32'd240);
        wr_reg(0, 32'hFFFF_FFFF);
        wr_reg(1, 32'hFFFF_FFFF);
        chk("R4 cols max", 32'(cols_o), 32'd1024);
        chk("R4 rows max", 32'(rows_o), 32'd1024);
        wr_reg(2, 32'h1234_5678);
        wr_reg(3, 32'h9ABC_DEF0);
        rd_check(2, 32'h1234_5678, 1'b0, "R2 timing2");
        rd_check(3, 32'h9ABC_DEF0, 1'b0, "R2 timing3");

        // R10 bases and current address
        wr_reg(4, 32'h8000_1000);
        wr_reg(5, 32'h8004_0000);
        rd_check(11, 32'h8000_1000, 1'b0, "R10 upper current");
        rd_check(12, 32'h8004_0000, 1'b0, "R10 lower current");

        // R6 enable without power: no events
        wr_reg(7, 32'h0000_0001);
        chk("R5 enable only", 32'(enabled_o), 32'h0);
        idle(2 * NF);
        rd_check(8, 32'h0, 1'b0, "R6 no event unpowered");

        // R5 fields, R6 events, R8 mask
        wr_reg(6, 32'h0000_0008);
        rd_check(6, 32'h0000_0008, 1'b0, "R2 mask");
        wr_reg(7, 32'h0000_0F0B);
        chk("R5 depth", 32'(depth_o), 32'd5);
        chk("R5 enabled", 32'(enabled_o), 32'h1);
        idle(NF + 1);
        rd_check(8, 32'h0000_000C, 1'b0, "R6 raw events");
        rd_check(9, 32'h0000_0008, 1'b0, "R8 masked");
        chk("R8 irq high", 32'(irq_o), 32'h1);

        // R9 clear and ignored writes
        wr_reg(10, 32'h0000_0008);
        idle(1);
        chk("R8 irq low after clear", 32'(irq_o), 32'h0);
        rd_check(8, 32'h0000_0004, 1'b0, "R9 w1c");
        wr_reg(8, 32'hFFFF_FFFF);
        wr_reg(9, 32'hFFFF_FFFF);
        wr_reg(11, 32'h0);
        rd_check(8, 32'h0000_0004, 1'b0, "R9 raw write ignored");
        rd_check(4, 32'h8000_1000, 1'b0, "R9 current write ignored");

        // R7 disable stops events
        wr_reg(7, 32'h0000_0000);
        wr_reg(10, 32'hFFFF_FFFF);
        idle(2 * NF);
        rd_check(8, 32'h0, 1'b0, "R7 disabled");

        // R7 restart mid-period
        wr_reg(7, 32'h0000_0801);
        idle(NF / 2 - 1);
        wr_reg(7, 32'h0000_0801);
        idle(NF / 2);
        rd_check(8, 32'h0, 1'b0, "R7 restart delays event");
        idle(NF);
        rd_check(8, 32'h0000_000C, 1'b0, "R7 event after restart");

        // R9 clear on the event cycle: set wins
        wr_reg(7, 32'h0000_0000);
        wr_reg(10, 32'h0000_000C);
        wr_reg(7, 32'h0000_0801);
        idle(NF - 1);
        wr_reg(10, 32'h0000_000C);
        rd_check(8, 32'h0000_000C, 1'b0, "R9 set beats clear");

        // R3 alternate map
        wr_reg(7, 32'h0000_0000);
        alt = 1'b1;
        idle(1);
        wr_reg(6, 32'h0000_0F01);
        wr_reg(7, 32'h0000_0004);
        chk("R3 ctrl via 6", 32'(enabled_o), 32'h1);
        rd_check(6, 32'h0000_0F01, 1'b0, "R3 read ctrl at 6");
        rd_check(7, 32'h0000_0004, 1'b0, "R3 read mask at 7");
        idle(NF + 2);
        chk("R3 irq via alt mask", 32'(irq_o), 32'h1);

        // R11 identification bytes, both variants
        for (int i = 0; i < 8; i++) rd_check(1016 + i, 32'(id_alt[i]), 1'b0, "R11 id alt");
        wr_reg(6, 32'h0000_0000);
        alt = 1'b0;
        idle(1);
        for (int i = 0; i < 8; i++) rd_check(1016 + i, 32'(id_std[i]), 1'b0, "R11 id std");

        // R12 unmapped
        rd_check(10, 32'h0, 1'b1, "R12 clear reads zero");
        rd_check(13, 32'h0, 1'b1, "R12 offset 13");
        rd_check(1015, 32'h0, 1'b1, "R12 below id");
        idle(1);
        chk("R12 error is a pulse", 32'(rd_err_o), 32'h0);
        summary();
    end
endmodule